// File: doc/BRIEF.md
# Ripple Adder-Subtractor with Alternating-Polarity Cells

This block adds or subtracts two N-bit two's-complement operands using a chain of full-adder cells. When the mode input is low the result is the sum. When it is high the block complements every bit of the second operand and forces the lowest carry-in to one, so the result is the difference. The block also reports the unsigned carry out of the top bit and a signed overflow flag. For every bit it exposes the generate, propagate and kill classification of the operand pair as the chain sees it.

The cells in the chain alternate between two flavours. Every cell has an inverting output, in the manner of a mirror-style full adder. Because complementing all three inputs of a full adder complements both of its outputs, the odd-position cells are fed complemented operands and take the complemented carry straight from their neighbour. They then emit a true carry and a true sum. No inverter sits on the carry path between stages. Sum bits from even cells, and the final carry when the width is odd, are restored to true polarity at the edge of the chain. The block is purely combinational, and its delay grows linearly with the width.

Top module: `addsub_ripple`

## Requirements
- R1: With subMode = 0, result equals (opA + opB) modulo 2^WIDTH.
- R2: With subMode = 1, result equals (opA - opB) modulo 2^WIDTH.
- R3: With subMode = 0, carryOut equals bit WIDTH of the unsigned sum opA + opB.
- R4: With subMode = 1, carryOut is 1 exactly when opA >= opB as unsigned numbers (no borrow).
- R5: overflow is 1 exactly when the signed two's-complement result does not fit in WIDTH bits. In add mode this means the operand sign bits are equal and the result sign differs from them. In subtract mode it means the operand sign bits differ and the result sign differs from the sign of opA.
- R6: With the effective operand defined as opB XOR {WIDTH{subMode}}, bit i of genBits is opA[i] AND effective[i], bit i of propBits is opA[i] XOR effective[i], and bit i of killBits is NOT opA[i] AND NOT effective[i]. For every bit exactly one of the three is set.
- R7: R1 to R5 hold for odd widths as well as even ones, where the last cell of the chain has inverted outputs.
- R8: Subtracting any value from itself gives result 0, carryOut 1 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand (minuend in subtract mode) |
| opB | input | WIDTH | Second operand (subtrahend in subtract mode) |
| subMode | input | 1 | 0 selects add, 1 selects subtract |
| result | output | WIDTH | Sum or difference, true polarity |
| carryOut | output | 1 | Carry out of the most significant bit |
| overflow | output | 1 | Signed two's-complement overflow |
| genBits | output | WIDTH | Per-bit generate flags |
| propBits | output | WIDTH | Per-bit propagate flags |
| killBits | output | WIDTH | Per-bit kill flags |

## Verification
Two instances are exercised, one 16 bits wide and one 7 bits wide. This separates a chain that ends on a true-output cell from one that ends on an inverted-output cell, which a sum-restore or carry-restore polarity slip would show. Seeded random operands in both modes catch wrong carries at any position. The directed cases cover all zeros, all ones, the most negative value, the most positive value plus one, and a value minus itself. These cases pin down the borrow sense of the carry, the overflow sign rules and the forced carry-in. The per-bit classification outputs are compared on every vector, which shows whether the subtrahend was complemented before the cells.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  // Strobes the mode decoder hands to the datapath.
  typedef struct packed {
    logic invertB;     // complement the second operand
    logic forceCarry;  // value injected as carry into bit 0
  } modeStrobes_t;

endpackage

// File: rtl/addsub_cell.sv
// Full-adder cell with inverting outputs. A complemented input set yields
// true outputs, so the same cell serves both positions in the chain.
module addsub_cell (
  input  logic cellA,
  input  logic cellB,
  input  logic cellCin,
  output logic nSum,
  output logic nCarry
);

  logic cellGen;
  logic cellProp;

  always_comb begin
    cellGen  = cellA & cellB;
    cellProp = cellA ^ cellB;
    nCarry   = ~(cellGen | (cellProp & cellCin));
    nSum     = ~(cellProp ^ cellCin);
  end

endmodule

// File: rtl/addsub_ctrl.sv
// Decodes the add/subtract selector into datapath strobes.
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic         subMode,
  output modeStrobes_t strobes
);

  always_comb begin
    strobes.invertB    = subMode;
    strobes.forceCarry = subMode;
  end

endmodule

// File: rtl/addsub_datapath.sv
// Alternating-polarity ripple chain. chainRaw[i] is the carry into bit i.
// It is stored complemented when i is odd, and true when i is even.
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  modeStrobes_t     strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic [WIDTH-1:0] genBits,
  output logic [WIDTH-1:0] propBits,
  output logic [WIDTH-1:0] killBits
);

  localparam int  MsbIdx    = WIDTH - 1;
  localparam bit  OutInv    = (WIDTH % 2) == 1;
  localparam bit  MsbCinInv = (MsbIdx % 2) == 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] rawSum;
  logic [WIDTH:0]   chainRaw;
  logic             carryIntoMsb;

  assign bEff        = opB ^ {WIDTH{strobes.invertB}};
  assign chainRaw[0] = strobes.forceCarry;

  assign genBits  = opA & bEff;
  assign propBits = opA ^ bEff;
  assign killBits = ~opA & ~bEff;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam bit CellInv = (i % 2) == 1;
    logic cellA;
    logic cellB;

    if (CellInv) begin : g_inv
      // Complemented operands meet a complemented carry, giving true outputs.
      assign cellA     = ~opA[i];
      assign cellB     = ~bEff[i];
      assign result[i] = rawSum[i];
    end else begin : g_true
      // True inputs give complemented outputs; restore the sum bit only.
      assign cellA     = opA[i];
      assign cellB     = bEff[i];
      assign result[i] = ~rawSum[i];
    end

    addsub_cell u_cell (
      .cellA  (cellA),
      .cellB  (cellB),
      .cellCin(chainRaw[i]),
      .nSum   (rawSum[i]),
      .nCarry (chainRaw[i+1])
    );
  end

  if (OutInv) begin : g_cout_inv
    assign carryOut = ~chainRaw[WIDTH];
  end else begin : g_cout_true
    assign carryOut = chainRaw[WIDTH];
  end

  if (MsbCinInv) begin : g_cmsb_inv
    assign carryIntoMsb = ~chainRaw[MsbIdx];
  end else begin : g_cmsb_true
    assign carryIntoMsb = chainRaw[MsbIdx];
  end

  assign overflow = carryIntoMsb ^ carryOut;

endmodule

// File: rtl/addsub_ripple.sv
// Thin top: mode decoder plus alternating-polarity datapath.
module addsub_ripple #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subMode,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic [WIDTH-1:0] genBits,
  output logic [WIDTH-1:0] propBits,
  output logic [WIDTH-1:0] killBits
);

  addsub_pkg::modeStrobes_t strobes;

  addsub_ctrl u_ctrl (
    .subMode(subMode),
    .strobes(strobes)
  );

  addsub_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut),
    .overflow(overflow),
    .genBits (genBits),
    .propBits(propBits),
    .killBits(killBits)
  );

endmodule

// File: rtl/addsub_checker.sv
module addsub_checker #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             subMode,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             overflow,
  input logic [WIDTH-1:0] genBits,
  input logic [WIDTH-1:0] propBits,
  input logic [WIDTH-1:0] killBits
);

  logic [WIDTH:0]   wideAdd;
  logic [WIDTH-1:0] diffRef;
  logic             signA;
  logic             signB;
  logic             signR;
  logic             knownIn;

  assign wideAdd = {1'b0, opA} + {1'b0, opB};
  assign diffRef = opA - opB;
  assign signA   = opA[WIDTH-1];
  assign signB   = opB[WIDTH-1];
  assign signR   = result[WIDTH-1];
  assign knownIn = !$isunknown({opA, opB, subMode});

  always_comb begin
    if (knownIn) begin
      // R1
      add_result_chk: assert (subMode || result == wideAdd[WIDTH-1:0])
        else $error("add result mismatch");
      // R2
      sub_result_chk: assert (!subMode || result == diffRef)
        else $error("subtract result mismatch");
      // R3
      add_carry_chk: assert (subMode || carryOut == wideAdd[WIDTH])
        else $error("add carry mismatch");
      // R4
      no_borrow_chk: assert (!subMode || carryOut == (opA >= opB))
        else $error("subtract carry mismatch");
      // R5
      signed_ovf_chk: assert (overflow == (subMode ? ((signA != signB) && (signR != signA))
                                                   : ((signA == signB) && (signR != signA))))
        else $error("overflow mismatch");
      // R6
      gpk_exclusive_chk: assert (((genBits ^ propBits ^ killBits) == {WIDTH{1'b1}}) &&
                                 ((genBits & propBits) == '0) &&
                                 ((genBits & killBits) == '0) &&
                                 ((propBits & killBits) == '0))
        else $error("generate/propagate/kill not exclusive");
      // R8
      self_sub_chk: assert (!(subMode && opA == opB) || (result == '0 && carryOut && !overflow))
        else $error("self subtraction not zero");
    end
  end

endmodule

bind addsub_ripple addsub_checker #(.WIDTH(WIDTH)) u_addsub_checker (
  .opA     (opA),
  .opB     (opB),
  .subMode (subMode),
  .result  (result),
  .carryOut(carryOut),
  .overflow(overflow),
  .genBits (genBits),
  .propBits(propBits),
  .killBits(killBits)
);

// File: tb/test_addsub_ripple.sv
module test_addsub_ripple;

  localparam int WE = 16;
  localparam int WO = 7;

  logic clk = 1'b0;
  logic rstN;
  always #10 clk = ~clk;  // 50 MHz

  logic [WE-1:0] aE, bE, rE, gE, pE, kE;
  logic          mE, cE, oE;
  logic [WO-1:0] aO, bO, rO, gO, pO, kO;
  logic          mO, cO, oO;

  int  vecCount  = 0;
  int  missCount = 0;
  bit  finished  = 0;

  addsub_ripple #(.WIDTH(WE)) i_addsub_ripple (
    .opA(aE), .opB(bE), .subMode(mE), .result(rE), .carryOut(cE),
    .overflow(oE), .genBits(gE), .propBits(pE), .killBits(kE)
  );

  addsub_ripple #(.WIDTH(WO)) i_addsub_ripple_odd (
    .opA(aO), .opB(bO), .subMode(mO), .result(rO), .carryOut(cO),
    .overflow(oO), .genBits(gO), .propBits(pO), .killBits(kO)
  );

  function automatic logic [31:0] widthMask(int w);
    return (32'd1 << w) - 32'd1;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drives one vector into the instance of width w and compares every output.
  task automatic apply(int w, logic [31:0] aIn, logic [31:0] bIn, logic m, string req);
    logic [31:0] mk, a, b, bx, s, res, gx, px, kx;
    logic [31:0] actR, actG, actP, actK;
    logic        cout, ovf, sa, sb, sr, actC, actO;
    mk   = widthMask(w);
    a    = aIn & mk;
    b    = bIn & mk;
    bx   = m ? (~b & mk) : b;
    s    = a + bx + {31'd0, m};
    res  = s & mk;
    cout = s[w];
    sa   = a[w-1];
    sb   = b[w-1];
    sr   = res[w-1];
    ovf  = m ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    gx   = a & bx;
    px   = a ^ bx;
    kx   = ~a & ~bx & mk;
    @(posedge clk);
    if (w == WE) begin
      aE = a[WE-1:0]; bE = b[WE-1:0]; mE = m;
    end else begin
      aO = a[WO-1:0]; bO = b[WO-1:0]; mO = m;
    end
    @(negedge clk);
    vecCount++;
    if (w == WE) begin
      actR = {16'd0, rE}; actC = cE; actO = oE;
      actG = {16'd0, gE}; actP = {16'd0, pE}; actK = {16'd0, kE};
    end else begin
      actR = {25'd0, rO}; actC = cO; actO = oO;
      actG = {25'd0, gO}; actP = {25'd0, pO}; actK = {25'd0, kO};
    end
    cmp(req, "result", actR, res);
    cmp(m ? "R4" : "R3", "carryOut", {31'd0, actC}, {31'd0, cout});
    cmp("R5", "overflow", {31'd0, actO}, {31'd0, ovf});
    cmp("R6", "genBits", actG, gx);
    cmp("R6", "propBits", actP, px);
    cmp("R6", "killBits", actK, kx);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    aE = '0; bE = '0; mE = 1'b0;
    aO = '0; bO = '0; mO = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Reset-state inputs: all zero operands in add mode (R1)
    apply(WE, 0, 0, 1'b0, "R1");
    apply(WO, 0, 0, 1'b0, "R7");

    // Directed corners, even width
    apply(WE, 32'hFFFF, 32'hFFFF, 1'b0, "R1");   // all ones add
    apply(WE, 32'hFFFF, 32'h0001, 1'b0, "R1");   // full carry ripple
    apply(WE, 32'h7FFF, 32'h0001, 1'b0, "R1");   // positive overflow
    apply(WE, 32'h8000, 32'h8000, 1'b0, "R1");   // most negative doubled
    apply(WE, 32'h8000, 32'h0001, 1'b1, "R2");   // most negative minus one
    apply(WE, 32'h0000, 32'h8000, 1'b1, "R2");   // zero minus most negative
    apply(WE, 32'h0000, 32'h0001, 1'b1, "R2");   // borrow everywhere
    apply(WE, 32'hFFFF, 32'hFFFF, 1'b1, "R8");
    apply(WE, 32'h8000, 32'h8000, 1'b1, "R8");
    apply(WE, 32'h0000, 32'h0000, 1'b1, "R8");

    // Directed corners, odd width
    apply(WO, 32'h7F, 32'h7F, 1'b0, "R7");
    apply(WO, 32'h7F, 32'h01, 1'b0, "R7");
    apply(WO, 32'h3F, 32'h01, 1'b0, "R7");
    apply(WO, 32'h40, 32'h01, 1'b1, "R7");
    apply(WO, 32'h00, 32'h01, 1'b1, "R7");
    apply(WO, 32'h55, 32'h55, 1'b1, "R8");
    apply(WO, 32'h40, 32'h40, 1'b1, "R8");

    // Seeded random operands in both modes
    for (int n = 0; n < 800; n++) begin
      logic m;
      m = 1'($urandom % 2);
      apply(WE, $urandom, $urandom, m, m ? "R2" : "R1");
    end
    for (int n = 0; n < 600; n++) begin
      apply(WO, $urandom, $urandom, 1'($urandom % 2), "R7");
    end
    for (int n = 0; n < 100; n++) begin
      logic [31:0] v;
      v = $urandom;
      apply(WE, v, v, 1'b1, "R8");
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule